// File: doc/BRIEF.md
# Quadrature Position Counter with Index Capture

This block turns the two phase-shifted channels of an incremental encoder into a signed position count. Each channel is brought into the clock domain through two flops and then passes a stability filter, so short glitches are dropped. Every valid edge on either channel moves the count by one step, which is x4 resolution. The direction of the step comes from which channel leads. A step that changes both channels in the same filtered sample cannot be decoded. Such a step leaves the count as it is and sets a sticky error flag.

A third input carries the once-per-revolution marker. On its filtered rising edge the block copies the live count into a separate capture register and sets a sticky "marker seen" flag. Control software polls a small read-only register window: a status word, the live count and the captured count. Reading the captured count acknowledges the marker. Reading the status word acknowledges the error.

Top module: `qpc_top`

## Requirements
- R1: After reset, the position, the captured position, both status flags and the read data are all zero.
- R2: With channel states written as AB, the forward order 00, 10, 11, 01, 00 raises the position by one for each state change.
- R3: The reverse order 00, 01, 11, 10, 00 lowers the position by one for each state change.
- R4: A change in which A and B both flip in the same filtered sample leaves the position unchanged. It also sets the error flag, status bit 1, which stays set until it is cleared.
- R5: A read of the status word at byte offset 0x04 returns the flags as they stand. It clears the error flag unless a new illegal change arrives in the same cycle, and it does not clear the marker flag.
- R6: A filtered rising edge on the index input copies the position into the capture register at offset 0x0C and sets the marker flag, status bit 0.
- R7: A read of offset 0x0C clears the marker flag unless a new capture happens in the same cycle. The captured value stays until the next index edge.
- R8: The position at offset 0x08 wraps modulo 2^DATA_W. One reverse step from zero reads all ones.
- R9: A level on A, B or index that lasts fewer than FILT_CNT clock cycles after synchronisation has no effect on the count, the capture register or the flags.
- R10: Read data appears one cycle after the read strobe and holds until the next read. Any offset other than 0x04, 0x08 or 0x0C reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| enc_idx_i | input | 1 | Encoder index marker, asynchronous |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Byte offset of the register to read |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
The bench builds the block with DATA_W = 32, ADDR_W = 6 and FILT_CNT = 3. With DATA_W at 32, a single reverse step from reset exercises the full-width wrap. With a short filter, one-cycle glitches fall clearly below the acceptance length, while held levels settle within a dozen cycles. Hundreds of random forward, reverse, illegal and index events can then be checked against a phase-table model. Directed cases cover reset, the read-side clearing of each flag and the reads of unmapped offsets.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_POS  = 8;
  localparam int unsigned OFS_IDX  = 12;
  localparam int unsigned BIT_SEEN = 0;
  localparam int unsigned BIT_ERR  = 1;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DN   = 2'd2,
    MV_BAD  = 2'd3
  } move_e;
endpackage

// File: rtl/qpc_sync_filt.sv
module qpc_sync_filt #(
  parameter int FILT_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_CNT > 1) ? $clog2(FILT_CNT) : 1;

  logic          s1_q, s2_q, filt_q, filt_n;
  logic [CW-1:0] cnt_q, cnt_n;

  // Accept a new level only after FILT_CNT consecutive differing samples
  always_comb begin
    filt_n = filt_q;
    cnt_n  = cnt_q;
    if (s2_q == filt_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT_CNT - 1)) begin
      filt_n = s2_q;
      cnt_n  = '0;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      filt_q <= filt_n;
      cnt_q  <= cnt_n;
    end
  end

  assign dout = filt_q;
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a,
  input  logic              b,
  output logic [DATA_W-1:0] pos,
  output logic              bad_evt
);
  logic              pa_q, pb_q;
  logic [DATA_W-1:0] pos_q, pos_n;
  move_e             mv;

  // Transition table over {previous A, previous B, A, B}
  always_comb begin
    unique case ({pa_q, pb_q, a, b})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: mv = MV_UP;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: mv = MV_DN;
      4'b0011, 4'b1100, 4'b0110, 4'b1001: mv = MV_BAD;
      default:                            mv = MV_NONE;
    endcase
  end

  always_comb begin
    pos_n = pos_q;
    if (mv == MV_UP)      pos_n = pos_q + DATA_W'(1);
    else if (mv == MV_DN) pos_n = pos_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      pos_q <= '0;
    end else begin
      pa_q  <= a;
      pb_q  <= b;
      pos_q <= pos_n;
    end
  end

  assign pos     = pos_q;
  assign bad_evt = (mv == MV_BAD);
endmodule

// File: rtl/qpc_regs.sv
module qpc_regs
  import qpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pos,
  input  logic              idx_f,
  input  logic              bad_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] idx_pos,
  output logic              idx_seen,
  output logic              err_flag
);
  logic              idx_prev_q;
  logic [DATA_W-1:0] cap_q, cap_n, rdata_q, rdata_n;
  logic              seen_q, seen_n, err_q, err_n;
  logic              idx_rise, rd_stat, rd_idx, rd_pos;
  logic [DATA_W-1:0] stat_word;

  assign idx_rise = idx_f & ~idx_prev_q;
  assign rd_stat  = rd_en && (rd_addr == ADDR_W'(OFS_STAT));
  assign rd_pos   = rd_en && (rd_addr == ADDR_W'(OFS_POS));
  assign rd_idx   = rd_en && (rd_addr == ADDR_W'(OFS_IDX));

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_SEEN] = seen_q;
    stat_word[BIT_ERR]  = err_q;
  end

  always_comb begin
    cap_n   = idx_rise ? pos : cap_q;
    seen_n  = idx_rise ? 1'b1 : (rd_idx ? 1'b0 : seen_q);
    err_n   = bad_evt ? 1'b1 : (rd_stat ? 1'b0 : err_q);
    rdata_n = rdata_q;
    if (rd_en) begin
      if (rd_stat)     rdata_n = stat_word;
      else if (rd_pos) rdata_n = pos;
      else if (rd_idx) rdata_n = cap_q;
      else             rdata_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_prev_q <= 1'b0;
      cap_q      <= '0;
      seen_q     <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      idx_prev_q <= idx_f;
      cap_q      <= cap_n;
      seen_q     <= seen_n;
      err_q      <= err_n;
      rdata_q    <= rdata_n;
    end
  end

  assign rd_data  = rdata_q;
  assign idx_pos  = cap_q;
  assign idx_seen = seen_q;
  assign err_flag = err_q;
endmodule

// File: rtl/qpc_top.sv
module qpc_top #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int FILT_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              enc_idx_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int NCH = 3;

  logic [NCH-1:0]    enc_raw, enc_f;
  logic [DATA_W-1:0] pos, idx_pos;
  logic              bad_evt, idx_seen, err_flag;

  assign enc_raw = {enc_idx_i, enc_b_i, enc_a_i};

  for (genvar g = 0; g < NCH; g++) begin : g_in
    qpc_sync_filt #(.FILT_CNT(FILT_CNT)) u_sf (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (enc_raw[g]),
      .dout (enc_f[g])
    );
  end

  qpc_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (enc_f[0]),
    .b      (enc_f[1]),
    .pos    (pos),
    .bad_evt(bad_evt)
  );

  qpc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos     (pos),
    .idx_f   (enc_f[2]),
    .bad_evt (bad_evt),
    .rd_en   (rd_en_i),
    .rd_addr (rd_addr_i),
    .rd_data (rd_data_o),
    .idx_pos (idx_pos),
    .idx_seen(idx_seen),
    .err_flag(err_flag)
  );
endmodule

// File: rtl/qpc_chk.sv
module qpc_chk
  import qpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_f,
  input logic              b_f,
  input logic              z_f,
  input logic [DATA_W-1:0] pos,
  input logic [DATA_W-1:0] idx_pos,
  input logic              idx_seen,
  input logic              err_flag,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr
);
  logic rd_stat, rd_idx;
  assign rd_stat = rd_en && (rd_addr == ADDR_W'(OFS_STAT));
  assign rd_idx  = rd_en && (rd_addr == ADDR_W'(OFS_IDX));

  // R2 R3 R8
  step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos == $past(pos) || pos == $past(pos) + DATA_W'(1)
              || pos == $past(pos) - DATA_W'(1)));

  // R4
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_f != $past(a_f) && b_f != $past(b_f)) |=> ($stable(pos) && err_flag));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !rd_stat) |=> err_flag);

  // R6
  idx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_f) |=> (idx_pos == $past(pos) && idx_seen));

  // R7
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx && !$rose(z_f)) |=> !idx_seen);

  // R5
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_seen && !rd_idx) |=> idx_seen);
endmodule

bind qpc_top qpc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_f     (enc_f[0]),
  .b_f     (enc_f[1]),
  .z_f     (enc_f[2]),
  .pos     (pos),
  .idx_pos (idx_pos),
  .idx_seen(idx_seen),
  .err_flag(err_flag),
  .rd_en   (rd_en_i),
  .rd_addr (rd_addr_i)
);

// File: tb/tb_qpc_top.sv
module tb_qpc_top;
  localparam int DW = 32, AW = 6, FC = 3, HOLD = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          a = 1'b0, b = 1'b0, z = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_pos = '0, m_cap = '0;
  bit            m_seen = 0, m_err = 0;
  int            m_ph = 0;

  qpc_top #(.DATA_W(DW), .ADDR_W(AW), .FILT_CNT(FC)) dut (
    .clk(clk), .rst_n(rst_n), .enc_a_i(a), .enc_b_i(b), .enc_idx_i(z),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  always #5 clk = ~clk;

  // Phase order 0..3 maps to AB = 00,10,11,01
  function automatic logic [1:0] ph_ab(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [DW-1:0] stat_exp();
    logic [DW-1:0] s = '0;
    s[0] = m_seen;
    s[1] = m_err;
    return s;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_rd(input int ofs, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = AW'(ofs);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    if (ofs == 4) m_err = 0;
    if (ofs == 12) m_seen = 0;
  endtask

  task automatic drive_ph(input int p);
    logic [1:0] ab;
    @(negedge clk);
    ab = ph_ab(p);
    a = ab[1];
    b = ab[0];
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic step(input int kind);  // 0 up, 1 down, 2 illegal
    if (kind == 0) begin m_ph = (m_ph + 1) & 3; m_pos = m_pos + 1; end
    else if (kind == 1) begin m_ph = (m_ph + 3) & 3; m_pos = m_pos - 1; end
    else begin m_ph = (m_ph + 2) & 3; m_err = 1; end
    drive_ph(m_ph);
  endtask

  task automatic idx_pulse();
    @(negedge clk); z = 1'b1;
    repeat (HOLD) @(negedge clk);
    m_cap = m_pos; m_seen = 1;
    z = 1'b0;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(8, d);  chk("R1 pos", d, '0);
    bus_rd(12, d); chk("R1 cap", d, '0);
    bus_rd(4, d);  chk("R1 stat", d, '0);

    // R8 wrap below zero, then back
    step(1); bus_rd(8, d); chk("R8 wrap", d, 32'hFFFF_FFFF);
    step(0); bus_rd(8, d); chk("R8 back", d, '0);

    // R2 forward full cycle
    for (int i = 0; i < 4; i++) begin step(0); bus_rd(8, d); chk("R2 fwd", d, m_pos); end
    // R3 reverse full cycle
    for (int i = 0; i < 6; i++) begin step(1); bus_rd(8, d); chk("R3 rev", d, m_pos); end

    // R4 illegal jump
    step(2); bus_rd(8, d); chk("R4 hold", d, m_pos);
    // R5 status shows err, read clears it
    begin
      logic [DW-1:0] e;
      e = stat_exp();
      bus_rd(4, d); chk("R5 stat err", d, e);
    end
    bus_rd(4, d); chk("R5 err cleared", d, '0);

    // R6 index capture
    step(0); step(0);
    idx_pulse();
    bus_rd(4, d); chk("R6 seen", d, 32'h1);
    bus_rd(4, d); chk("R5 seen kept", d, 32'h1);
    step(0);
    bus_rd(12, d); chk("R6 cap", d, m_cap);
    bus_rd(4, d); chk("R7 seen cleared", d, '0);
    bus_rd(12, d); chk("R7 cap kept", d, m_cap);

    // R9 short glitches on A and index
    @(negedge clk); a = ~a; @(negedge clk); a = ~a;
    @(negedge clk); z = 1'b1; @(negedge clk); z = 1'b0;
    repeat (HOLD) @(negedge clk);
    bus_rd(8, d); chk("R9 glitch pos", d, m_pos);
    bus_rd(4, d); chk("R9 glitch flags", d, '0);

    // R10 unmapped reads and hold
    bus_rd(0, d);  chk("R10 unmapped 0x00", d, '0);
    bus_rd(16, d); chk("R10 unmapped 0x10", d, '0);
    bus_rd(8, d);
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, m_pos);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(99));
      if (r < 45) step(0);
      else if (r < 90) step(1);
      else if (r < 95) step(2);
      else idx_pulse();
      bus_rd(8, d); chk("R2 R3 R4 rand pos", d, m_pos);
      if ((i % 10) == 9) begin
        logic [DW-1:0] e;
        e = stat_exp();
        bus_rd(4, d); chk("R5 R4 rand stat", d, e);
        bus_rd(12, d); chk("R6 R7 rand cap", d, m_cap);
      end
    end
    finish_run();
  end
endmodule